// File: doc/BRIEF.md
# SIMD Floating-Point Minimum/Maximum Unit

This unit selects, lane by lane, the smaller or the larger of two 128-bit vectors of IEEE-754 values. The operands are a first (destination) vector and a second (source) vector. A control input picks minimum or maximum. Another picks 32-bit or 64-bit lanes, and a third picks whether every lane is processed (packed) or only the lowest one (scalar). The choice in each lane comes from one hardware less-than comparator, so the result is deliberately asymmetric in operand order. When the comparison is false, the second operand wins. That case covers any NaN and the pair of signed zeros.

The unit is combinational. By default a single output register stage is added, so a result appears one clock after it is presented with `valid_i`. An invalid-operation flag reports a NaN of either kind in any lane that takes part in the operation. It is used as the min/max execution slice of a vector floating-point datapath. Decode, rounding, exception masking and trapping sit outside it.

Top module: `simd_minmax`

## Requirements
- R1: With `op_max_i`=0, each active result lane is the first-operand lane when first < second under an ordered less-than, otherwise the second-operand lane.
- R2: With `op_max_i`=1, each active result lane is the first-operand lane when second < first under the same less-than, otherwise the second-operand lane.
- R3: If either operand lane is a NaN (exponent all ones, fraction non-zero, quiet or signalling), the result lane is the second-operand lane bit for bit, and `invalid_o` is 1.
- R4: For the signed-zero pair (-0,+0) or (+0,-0), the result lane is the second-operand lane for both min and max.
- R5: The ordering is sign-magnitude. Among negatives the larger magnitude is smaller. -inf lies below every non-NaN value and +inf lies above every non-NaN value. Denormals order by magnitude.
- R6: `dbl_i`=1 gives 64-bit lanes (lane k = bits 64k+63:64k). `dbl_i`=0 gives 32-bit lanes (lane k = bits 32k+31:32k). `scalar_i`=0 processes all lanes, and `scalar_i`=1 processes only lane 0.
- R7: In scalar forms, result bits above lane 0 equal the first operand's bits unchanged.
- R8: `invalid_o` is 1 only if an active lane holds a NaN. NaNs in inactive lanes of a scalar operation never set it.
- R9: `valid_o` and the registered result follow `valid_i` by one cycle. Reset clears `valid_o`, `invalid_o` and `res_o`. `invalid_o` is 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| a_i | input | 128 | First (destination) operand vector |
| b_i | input | 128 | Second (source) operand vector |
| op_max_i | input | 1 | 0 = minimum, 1 = maximum |
| dbl_i | input | 1 | 0 = 32-bit lanes, 1 = 64-bit lanes |
| scalar_i | input | 1 | 0 = packed, 1 = lowest lane only |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Result vector |
| invalid_o | output | 1 | NaN seen in an active lane |

## Verification
Selecting the second operand because of a NaN and raising the invalid flag happen in the same cycle. In scalar forms, upper-lane pass-through can also coincide with a NaN that sits in an upper lane and must be ignored. The bench provokes both with scalar operands whose lane 0 is either ordinary or a NaN while the upper lanes carry NaNs. It judges the result and the flag together against a reference model that orders values by a mapped integer key, in a different way from the hardware comparator. Every special value is paired with every other in both operand orders, for both operations and all four forms, and random vectors follow.

// File: rtl/simd_minmax_pkg.sv
package simd_minmax_pkg;
  localparam int SP_W   = 32;
  localparam int SP_EXP = 8;
  localparam int DP_W   = 64;
  localparam int DP_EXP = 11;

  typedef enum logic {
    OP_MIN = 1'b0,
    OP_MAX = 1'b1
  } mm_op_e;
endpackage

// File: rtl/fp_lt_cmp.sv
module fp_lt_cmp #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic         lt_o,
  output logic         nan_o
);
  localparam int FRAC_W = W - 1 - EXP_W;

  logic         sx, sy, nan_x, nan_y, both_zero;
  logic [W-2:0] mx, my;

  assign sx    = x_i[W-1];
  assign sy    = y_i[W-1];
  assign mx    = x_i[W-2:0];
  assign my    = y_i[W-2:0];
  assign nan_x = (&x_i[W-2:FRAC_W]) & (|x_i[FRAC_W-1:0]);
  assign nan_y = (&y_i[W-2:FRAC_W]) & (|y_i[FRAC_W-1:0]);
  assign both_zero = (mx == '0) && (my == '0);
  assign nan_o = nan_x | nan_y;

  // ordered less-than: false on NaN and on equal values (incl. +0/-0)
  always_comb begin
    if (nan_o || both_zero) lt_o = 1'b0;
    else if (sx != sy)      lt_o = sx;
    else if (sx)            lt_o = (mx > my);
    else                    lt_o = (mx < my);
  end
endmodule

// File: rtl/mm_lane.sv
module mm_lane
  import simd_minmax_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  mm_op_e       op_i,
  output logic [W-1:0] res_o,
  output logic         nan_o
);
  logic [W-1:0] x, y;
  logic         lt;

  // max swaps comparator inputs so a single less-than serves both
  assign x = (op_i == OP_MAX) ? b_i : a_i;
  assign y = (op_i == OP_MAX) ? a_i : b_i;

  fp_lt_cmp #(.W(W), .EXP_W(EXP_W)) u_cmp (
    .x_i  (x),
    .y_i  (y),
    .lt_o (lt),
    .nan_o(nan_o)
  );

  assign res_o = lt ? a_i : b_i;
endmodule

// File: rtl/mm_vec.sv
module mm_vec
  import simd_minmax_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [VEC_W-1:0]   a_i,
  input  logic [VEC_W-1:0]   b_i,
  input  mm_op_e             op_i,
  output logic [VEC_W-1:0]   res_o,
  output logic [VEC_W/W-1:0] nan_o
);
  localparam int LANES = VEC_W / W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mm_lane #(.W(W), .EXP_W(EXP_W)) u_lane (
      .a_i  (a_i[k*W +: W]),
      .b_i  (b_i[k*W +: W]),
      .op_i (op_i),
      .res_o(res_o[k*W +: W]),
      .nan_o(nan_o[k])
    );
  end
endmodule

// File: rtl/simd_minmax.sv
module simd_minmax
  import simd_minmax_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             op_max_i,
  input  logic             dbl_i,
  input  logic             scalar_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic             invalid_o
);
  localparam int SP_LANES = VEC_W / SP_W;
  localparam int DP_LANES = VEC_W / DP_W;

  mm_op_e              op;
  logic [VEC_W-1:0]    sp_res, dp_res, res_c;
  logic [SP_LANES-1:0] sp_nan;
  logic [DP_LANES-1:0] dp_nan;
  logic                inv_c;

  assign op = op_max_i ? OP_MAX : OP_MIN;

  mm_vec #(.VEC_W(VEC_W), .W(SP_W), .EXP_W(SP_EXP)) u_sp (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(sp_res), .nan_o(sp_nan)
  );

  mm_vec #(.VEC_W(VEC_W), .W(DP_W), .EXP_W(DP_EXP)) u_dp (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(dp_res), .nan_o(dp_nan)
  );

  always_comb begin
    unique case ({dbl_i, scalar_i})
      2'b00: begin res_c = sp_res; inv_c = |sp_nan; end
      2'b01: begin res_c = {a_i[VEC_W-1:SP_W], sp_res[SP_W-1:0]}; inv_c = sp_nan[0]; end
      2'b10: begin res_c = dp_res; inv_c = |dp_nan; end
      default: begin res_c = {a_i[VEC_W-1:DP_W], dp_res[DP_W-1:0]}; inv_c = dp_nan[0]; end
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic             vld_q, inv_q;
    logic [VEC_W-1:0] res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        inv_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= valid_i;
        inv_q <= valid_i & inv_c;
        if (valid_i) res_q <= res_c;
      end
    end
    assign valid_o   = vld_q;
    assign invalid_o = inv_q;
    assign res_o     = res_q;
  end else begin : g_comb
    assign valid_o   = valid_i;
    assign invalid_o = valid_i & inv_c;
    assign res_o     = res_c;
  end
endmodule

// File: rtl/simd_minmax_chk.sv
module simd_minmax_chk #(
  parameter int VEC_W   = 128,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [VEC_W-1:0] a_i,
  input logic [VEC_W-1:0] b_i,
  input logic             dbl_i,
  input logic             scalar_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] res_o,
  input logic             invalid_o
);
  function automatic logic sp_nan(input logic [31:0] v);
    return (&v[30:23]) && (|v[22:0]);
  endfunction

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R9: no flag without a result
  a_r9_flag_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !invalid_o);

  if (REG_OUT) begin : g_seq
    // R9
    a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> valid_o == $past(valid_i));

    // R7
    a_r7_scalar_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && valid_o && $past(scalar_i)
      |-> res_o[VEC_W-1:64] == $past(a_i[VEC_W-1:64]));

    // R6: low bits always come from one operand
    a_r6_lane_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && valid_o
      |-> (res_o[31:0] == $past(a_i[31:0])) || (res_o[31:0] == $past(b_i[31:0])));

    // R3
    a_r3_nan_gives_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && valid_o && !$past(dbl_i)
      && (sp_nan($past(a_i[31:0])) || sp_nan($past(b_i[31:0])))
      |-> (res_o[31:0] == $past(b_i[31:0])) && invalid_o);
  end
endmodule

bind simd_minmax simd_minmax_chk #(.VEC_W(VEC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .dbl_i    (dbl_i),
  .scalar_i (scalar_i),
  .valid_o  (valid_o),
  .res_o    (res_o),
  .invalid_o(invalid_o)
);

// File: tb/simd_minmax_tb.sv
`timescale 1ns/1ps
module simd_minmax_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] a_i = '0, b_i = '0;
  logic         op_max_i = 1'b0, dbl_i = 1'b0, scalar_i = 1'b0;
  logic         valid_o, invalid_o;
  logic [127:0] res_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [127:0] res;
    logic         inv;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  simd_minmax u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .op_max_i(op_max_i), .dbl_i(dbl_i), .scalar_i(scalar_i),
    .valid_o(valid_o), .res_o(res_o), .invalid_o(invalid_o)
  );

  // ---- reference model: ordering by integer key ----
  function automatic logic is_nan(input logic [63:0] v, input bit dbl);
    if (dbl) return (v[62:52] == 11'h7ff) && (v[51:0] != 0);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  function automatic logic [63:0] fkey(input logic [63:0] v, input bit dbl);
    logic [63:0] t;
    t = dbl ? v : {v[31:0], 32'h0};
    if (t[62:0] == 0) t = 64'h0;
    return t[63] ? ~t : (t | 64'h8000_0000_0000_0000);
  endfunction

  function automatic logic [63:0] ref_lane(input logic [63:0] a, input logic [63:0] b,
                                           input bit mx, input bit dbl);
    bit pick_a;
    if (is_nan(a, dbl) || is_nan(b, dbl)) return b;
    pick_a = mx ? (fkey(b, dbl) < fkey(a, dbl)) : (fkey(a, dbl) < fkey(b, dbl));
    return pick_a ? a : b;
  endfunction

  task automatic ref_vec(input logic [127:0] a, input logic [127:0] b, input bit mx,
                         input bit dbl, input bit scal,
                         output logic [127:0] r, output logic inv);
    int w, n;
    logic [63:0] la, lb;
    w = dbl ? 64 : 32;
    n = scal ? 1 : 128 / w;
    r = a;
    inv = 1'b0;
    for (int k = 0; k < n; k++) begin
      la = dbl ? a[k*64 +: 64] : {32'h0, a[k*32 +: 32]};
      lb = dbl ? b[k*64 +: 64] : {32'h0, b[k*32 +: 32]};
      if (is_nan(la, dbl) || is_nan(lb, dbl)) inv = 1'b1;
      if (dbl) r[k*64 +: 64] = ref_lane(la, lb, mx, 1'b1);
      else     r[k*32 +: 32] = ref_lane(la, lb, mx, 1'b0)[31:0];
    end
  endtask

  function automatic string cat(input logic [63:0] a, input logic [63:0] b,
                                input bit mx, input bit dbl);
    logic [63:0] ma, mb;
    ma = dbl ? {1'b0, a[62:0]} : {33'h0, a[30:0]};
    mb = dbl ? {1'b0, b[62:0]} : {33'h0, b[30:0]};
    if (is_nan(a, dbl) || is_nan(b, dbl)) return "R3";
    if (ma == 0 && mb == 0) return "R4";
    return mx ? "R2/R5" : "R1/R5";
  endfunction

  // ---- driver ----
  task automatic drive(input logic [127:0] a, input logic [127:0] b, input bit mx,
                       input bit dbl, input bit scal, input string tag);
    exp_t e;
    @(negedge clk);
    a_i = a; b_i = b; op_max_i = mx; dbl_i = dbl; scalar_i = scal; valid_i = 1'b1;
    ref_vec(a, b, mx, dbl, scal, e.res, e.inv);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // ---- monitor ----
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      n_cmp++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected valid_o actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (res_o !== e.res || invalid_o !== e.inv) begin
          n_bad++;
          $display("FAIL %s res actual=%h/%b expected=%h/%b", e.tag, res_o, invalid_o,
                   e.res, e.inv);
        end
      end
    end
  end

  logic [31:0] sp_v[13] = '{32'h0000_0000, 32'h8000_0000, 32'h3f80_0000, 32'hbf80_0000,
                            32'h4000_0000, 32'hc000_0000, 32'h7f80_0000, 32'hff80_0000,
                            32'h7fc0_0000, 32'h7f80_0001, 32'h0000_0001, 32'h8000_0001,
                            32'h7f7f_ffff};
  logic [63:0] dp_v[13] = '{64'h0, 64'h8000_0000_0000_0000, 64'h3ff0_0000_0000_0000,
                            64'hbff0_0000_0000_0000, 64'h4000_0000_0000_0000,
                            64'hc000_0000_0000_0000, 64'h7ff0_0000_0000_0000,
                            64'hfff0_0000_0000_0000, 64'h7ff8_0000_0000_0000,
                            64'h7ff0_0000_0000_0001, 64'h1, 64'h8000_0000_0000_0001,
                            64'h7fef_ffff_ffff_ffff};

  task automatic chk(input bit c, input string tag, input logic [127:0] act,
                     input logic [127:0] expv);
    n_cmp++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] a, b, up;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(valid_o == 1'b0, "R9 reset valid_o", {127'h0, valid_o}, 128'h0);
    chk(invalid_o == 1'b0, "R9 reset invalid_o", {127'h0, invalid_o}, 128'h0);
    chk(res_o == 128'h0, "R9 reset res_o", res_o, 128'h0);
    rst_n = 1'b1;
    idle(2);

    // directed: R5 negatives, R8 ignored upper NaNs, R4 zero order
    drive({4{32'hc000_0000}}, {4{32'hbf80_0000}}, 1'b0, 1'b0, 1'b0, "R5 -2 min -1");
    drive({2{64'hfff0_0000_0000_0000}}, {2{64'hc000_0000_0000_0000}}, 1'b1, 1'b1, 1'b0,
          "R5 -inf max -2");
    drive({{3{32'h7fc0_0000}}, 32'h3f80_0000}, {{3{32'h7f80_0001}}, 32'h4000_0000},
          1'b0, 1'b0, 1'b1, "R8 upper NaNs ignored scalar single");
    drive({64'h7ff8_0000_0000_0000, 64'h3ff0_0000_0000_0000},
          {64'h7ff8_0000_0000_0000, 64'h4000_0000_0000_0000}, 1'b1, 1'b1, 1'b1,
          "R8 upper NaN ignored scalar double");
    drive({32'h0, 32'h8000_0000, 32'h3f80_0000, 32'hc000_0000},
          {32'h8000_0000, 32'h0, 32'h4000_0000, 32'hbf80_0000}, 1'b1, 1'b0, 1'b0,
          "R6/R4 mixed packed single");
    idle(3);
    chk(valid_o == 1'b0 && invalid_o == 1'b0, "R9 idle outputs low",
        {126'h0, valid_o, invalid_o}, 128'h0);

    // every special pair, both orders, both ops, four forms
    for (int i = 0; i < 13; i++)
      for (int j = 0; j < 13; j++)
        for (int m = 0; m < 2; m++) begin
          for (int k = 0; k < 4; k++) begin
            a[k*32 +: 32] = sp_v[i];
            b[k*32 +: 32] = sp_v[(j + k) % 13];
          end
          drive(a, b, m[0], 1'b0, 1'b0,
                {"R6 ", cat({32'h0, sp_v[i]}, {32'h0, sp_v[j]}, m[0], 1'b0)});
          up = rnd128();
          drive({up[127:32], sp_v[i]}, {up[31:0], up[127:64], sp_v[j]}, m[0], 1'b0, 1'b1,
                {"R7 ", cat({32'h0, sp_v[i]}, {32'h0, sp_v[j]}, m[0], 1'b0)});
          drive({dp_v[(i + 1) % 13], dp_v[i]}, {dp_v[(j + 3) % 13], dp_v[j]}, m[0], 1'b1,
                1'b0, {"R6 ", cat(dp_v[i], dp_v[j], m[0], 1'b1)});
          drive({up[127:64], dp_v[i]}, {up[63:0], dp_v[j]}, m[0], 1'b1, 1'b1,
                {"R7 ", cat(dp_v[i], dp_v[j], m[0], 1'b1)});
        end

    // random operands in all forms
    for (int n = 0; n < 800; n++) begin
      a = rnd128();
      b = (n % 5 == 0) ? {a[127:96], rnd128()[95:0]} : rnd128();
      drive(a, b, n[0], n[1], n[2], "R1/R2/R6 random");
    end
    idle(4);
    chk(sb.size() == 0, "R9 all results returned", 128'(sb.size()), 128'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule